// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

The controller collects interrupt requests from a set of system sources and sends one of them at a time to a single core. Each source has a programmable priority. A lower number means a more urgent source. Among the pending sources, the controller picks the most urgent one. When several sources share that priority, the lowest source number wins. The chosen source is offered to the core only when it is strictly more urgent than the interrupt the core is already serving.

The core works through a register-style handshake:
- It reads the offered source number from `curSid`.
- It writes the same number back on the acknowledge port. This moves the source from pending to active.
- It later writes the number on the end port. This retires the source.

A more urgent source can interrupt one that is being served, so active sources nest. The controller keeps them on a last-in, first-out stack. Ending the innermost source restores the urgency of the next outer one, or the idle level when the stack is empty.

An end write that does not name the innermost active source is discarded and raises a sticky error flag. That flag is itself routed to the highest-numbered source, so the core services the error like any other interrupt.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset:
  - `irq` is 0.
  - All pending and active bits are 0.
  - `errFlag` is 0.
  - `actPrio` holds the idle value 2^PRIO_W (8 by default).
- R2: A `cfgWe` pulse stores `cfgPrio` as the priority of source `cfgSrc`. A numerically smaller priority is more urgent.
- R3: Among the pending sources, the most urgent is selected. On a tie, the lowest source number is selected.
- R4: The selected source is offered only when its priority is numerically below `actPrio`. Offering loads its number into `curSid` and raises `irq` one cycle after its pending bit is visible. `curSid` stays stable while `irq` is high and no acknowledge arrives.
- R5: An acknowledge is accepted only when `ackWe` is high, `irq` is high and `ackSid` equals `curSid`. An accepted acknowledge:
  - drops `irq`,
  - clears the source's pending bit,
  - sets its active bit,
  - makes its priority the value of `actPrio`.

  Any other acknowledge write changes nothing.
- R6: While a source is active, a strictly more urgent source can be offered and acknowledged. Both active bits are then set together.
- R7: The nesting stack has 2^PRIO_W entries and never overflows. After a valid end, `actPrio` returns to the priority of the next outer active source, or to the idle value when none remain.
- R8: An end write is valid only when it names the innermost active source. A valid end clears that source's active bit.
- R9: An end write that is not valid changes no active bit and sets `errFlag`. The flag stays set until it is cleared as described in R10.
- R10: Setting `errFlag` marks source NUM_SRC-1 (7 by default) pending. Acknowledging source NUM_SRC-1 clears `errFlag`.
- R11: A request sets a sticky pending bit. Only an acknowledge clears it. A request arriving while the source is active sets the bit again, but the source cannot be offered at its own priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Priority write strobe |
| cfgSrc | input | SID_W | Source whose priority is written |
| cfgPrio | input | PRIO_W | Priority value to store |
| srcReq | input | NUM_SRC | Request inputs, one per source |
| ackWe | input | 1 | Acknowledge write strobe |
| ackSid | input | SID_W | Source number written back as acknowledge |
| endWe | input | 1 | End write strobe |
| endSid | input | SID_W | Source number to retire |
| irq | output | 1 | Interrupt line to the core |
| curSid | output | SID_W | Number of the offered source (read register) |
| actPrio | output | PRIO_W+1 | Current active priority; 2^PRIO_W when idle |
| pendVec | output | NUM_SRC | Pending bit of each source |
| actVec | output | NUM_SRC | Active bit of each source |
| errFlag | output | 1 | Sticky flag for an invalid end write |

## Verification
A corrupt nesting stack shows up at `actPrio` on the first valid end write. The restored priority is then wrong, and the next `irq` decision goes wrong one cycle later. A wrong pending or active bit shows on `pendVec` or `actVec` in the cycle after the write that caused it. It also shows as a missing or extra `irq` one cycle after that. The directed sequences deliberately walk the stack through two levels of nesting, an out-of-order end and an end on an idle controller, so that each of these faults surfaces within a few cycles.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  // one-cycle strobes from the control into the datapath
  typedef struct packed {
    logic loadCur;  // capture selected source as the offered one
    logic doAck;    // accepted acknowledge: pending -> active, push
    logic doEnd;    // valid end: pop innermost active source
    logic setErr;   // invalid end write
    logic clrErr;   // error source acknowledged
  } nirq_strobe_t;
endpackage

// File: rtl/nest_irq_select.sv
module nest_irq_select #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int SID_W   = 3
) (
  input  logic [NUM_SRC-1:0]        pendVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic                      bestValid,
  output logic [SID_W-1:0]          bestSid,
  output logic [PRIO_W-1:0]         bestPrio
);
  // ascending scan with strict compare: ties keep the lower source number
  always_comb begin
    bestValid = 1'b0;
    bestSid   = '0;
    bestPrio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendVec[i] && (!bestValid || prioFlat[i*PRIO_W +: PRIO_W] < bestPrio)) begin
        bestValid = 1'b1;
        bestSid   = SID_W'(i);
        bestPrio  = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/nest_irq_control.sv
module nest_irq_control
  import nest_irq_pkg::*;
#(
  parameter int PRIO_W  = 3,
  parameter int SID_W   = 3,
  parameter int ERR_SID = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bestValid,
  input  logic [PRIO_W-1:0] bestPrio,
  input  logic [PRIO_W:0]   actPrio,
  input  logic [SID_W-1:0]  curSid,
  input  logic [SID_W-1:0]  topSid,
  input  logic              stkEmpty,
  input  logic              ackWe,
  input  logic [SID_W-1:0]  ackSid,
  input  logic              endWe,
  input  logic [SID_W-1:0]  endSid,
  output logic              irq,
  output nirq_strobe_t      strb
);
  logic irqQ;
  logic endOk;

  always_comb begin
    strb         = '0;
    strb.doAck   = irqQ && ackWe && (ackSid == curSid);
    strb.loadCur = !irqQ && bestValid && ({1'b0, bestPrio} < actPrio);
    endOk        = !stkEmpty && (endSid == topSid);
    strb.doEnd   = endWe && !strb.doAck && endOk;
    strb.setErr  = endWe && !strb.doAck && !endOk;
    strb.clrErr  = strb.doAck && (curSid == SID_W'(ERR_SID));
  end

  always_ff @(posedge clk) begin
    if (!rstN)             irqQ <= 1'b0;
    else if (strb.loadCur) irqQ <= 1'b1;
    else if (strb.doAck)   irqQ <= 1'b0;
  end

  assign irq = irqQ;

  // R5: a matching write-back while offering always drops the line
  a_r5_ack_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && ackWe && ackSid == curSid) |=> !irqQ);
endmodule

// File: rtl/nest_irq_datapath.sv
module nest_irq_datapath
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int SID_W   = 3,
  parameter int ERR_SID = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  nirq_strobe_t              strb,
  input  logic                      cfgWe,
  input  logic [SID_W-1:0]          cfgSrc,
  input  logic [PRIO_W-1:0]         cfgPrio,
  input  logic [NUM_SRC-1:0]        srcReq,
  input  logic [SID_W-1:0]          bestSid,
  input  logic [PRIO_W-1:0]         bestPrio,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic [NUM_SRC-1:0]        actVec,
  output logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic [SID_W-1:0]          curSid,
  output logic [PRIO_W-1:0]         curPrio,
  output logic [PRIO_W:0]           actPrio,
  output logic [SID_W-1:0]          topSid,
  output logic                      stkEmpty,
  output logic                      errFlag
);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int DEP_W = $clog2(DEPTH + 1);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W-1:0]  prioQ   [NUM_SRC];
  logic [NUM_SRC-1:0] pendQ, actQ, ackMask, endMask, reqEff;
  logic [SID_W-1:0]   curSidQ;
  logic [PRIO_W-1:0]  curPrioQ;
  logic [SID_W-1:0]   stkSid  [DEPTH];
  logic [PRIO_W-1:0]  stkPrio [DEPTH];
  logic [DEP_W-1:0]   depthQ;
  logic [PRIO_W-1:0]  topPrio;
  logic               errQ;

  // per-source priority registers
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPrio
    always_ff @(posedge clk) begin
      if (!rstN)                                prioQ[g] <= '0;
      else if (cfgWe && cfgSrc == SID_W'(g))    prioQ[g] <= cfgPrio;
    end
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioQ[g];
  end

  always_comb begin
    ackMask = '0;
    endMask = '0;
    if (strb.doAck) ackMask[curSidQ] = 1'b1;
    if (strb.doEnd) endMask[topSid]  = 1'b1;
    reqEff = srcReq;
    if (strb.setErr) reqEff[ERR_SID] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      actQ     <= '0;
      curSidQ  <= '0;
      curPrioQ <= '0;
      errQ     <= 1'b0;
    end else begin
      pendQ <= (pendQ & ~ackMask) | reqEff;
      actQ  <= (actQ | ackMask) & ~endMask;
      if (strb.loadCur) begin
        curSidQ  <= bestSid;
        curPrioQ <= bestPrio;
      end
      if (strb.setErr)      errQ <= 1'b1;
      else if (strb.clrErr) errQ <= 1'b0;
    end
  end

  // nesting stack: entry k holds the (k+1)-th active source from the outside
  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ <= '0;
    end else if (strb.doAck) begin
      depthQ <= depthQ + 1'b1;
    end else if (strb.doEnd) begin
      depthQ <= depthQ - 1'b1;
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : gStk
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stkSid[k]  <= '0;
        stkPrio[k] <= '0;
      end else if (strb.doAck && depthQ == DEP_W'(k)) begin
        stkSid[k]  <= curSidQ;
        stkPrio[k] <= curPrioQ;
      end
    end
  end

  always_comb begin
    topSid  = '0;
    topPrio = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (depthQ == DEP_W'(k + 1)) begin
        topSid  = stkSid[k];
        topPrio = stkPrio[k];
      end
    end
  end

  assign stkEmpty = (depthQ == '0);
  assign actPrio  = stkEmpty ? IDLE_PRIO : {1'b0, topPrio};
  assign pendVec  = pendQ;
  assign actVec   = actQ;
  assign curSid   = curSidQ;
  assign curPrio  = curPrioQ;
  assign errFlag  = errQ;

  // R7: each push is strictly more urgent, so depth stays within the level count
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= DEP_W'(DEPTH));
  a_r7_push_ordered: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAck |-> ({1'b0, curPrioQ} < actPrio));
  // R8: a valid end retires the innermost source
  a_r8_end_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.doEnd |=> !actQ[$past(topSid)]);
  // R5: an accepted acknowledge makes the source active
  a_r5_ack_activates: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAck |=> actQ[$past(curSidQ)]);
  // R9: the error flag holds until the error source is acknowledged
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strb.clrErr) |=> errQ);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int SID_W  = $clog2(NUM_SRC),
  localparam int ERR_SID = NUM_SRC - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [SID_W-1:0]   cfgSrc,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               ackWe,
  input  logic [SID_W-1:0]   ackSid,
  input  logic               endWe,
  input  logic [SID_W-1:0]   endSid,
  output logic               irq,
  output logic [SID_W-1:0]   curSid,
  output logic [PRIO_W:0]    actPrio,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] actVec,
  output logic               errFlag
);
  nirq_strobe_t              strb;
  logic                      bestValid;
  logic [SID_W-1:0]          bestSid, topSid;
  logic [PRIO_W-1:0]         bestPrio, curPrio;
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic                      stkEmpty;

  nest_irq_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SID_W(SID_W)) uSel (
    .pendVec(pendVec), .prioFlat(prioFlat),
    .bestValid(bestValid), .bestSid(bestSid), .bestPrio(bestPrio));

  nest_irq_control #(.PRIO_W(PRIO_W), .SID_W(SID_W), .ERR_SID(ERR_SID)) uCtl (
    .clk(clk), .rstN(rstN), .bestValid(bestValid), .bestPrio(bestPrio),
    .actPrio(actPrio), .curSid(curSid), .topSid(topSid), .stkEmpty(stkEmpty),
    .ackWe(ackWe), .ackSid(ackSid), .endWe(endWe), .endSid(endSid),
    .irq(irq), .strb(strb));

  nest_irq_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SID_W(SID_W),
                      .ERR_SID(ERR_SID)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWe(cfgWe), .cfgSrc(cfgSrc),
    .cfgPrio(cfgPrio), .srcReq(srcReq), .bestSid(bestSid), .bestPrio(bestPrio),
    .pendVec(pendVec), .actVec(actVec), .prioFlat(prioFlat), .curSid(curSid),
    .curPrio(curPrio), .actPrio(actPrio), .topSid(topSid), .stkEmpty(stkEmpty),
    .errFlag(errFlag));

  // R4: an offered source always outranks the one being served
  a_r4_irq_outranks: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ({1'b0, curPrio} < actPrio));
  // R4: the offered number holds until acknowledged
  a_r4_cur_stable: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ackWe) |=> $stable(curSid));
endmodule

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
  localparam int NUM_SRC = 8;
  localparam int PRIO_W  = 3;
  localparam int SID_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0, ackWe = 1'b0, endWe = 1'b0;
  logic [SID_W-1:0]  cfgSrc = '0, ackSid = '0, endSid = '0;
  logic [PRIO_W-1:0] cfgPrio = '0;
  logic [NUM_SRC-1:0] srcReq = '0;
  logic irq, errFlag;
  logic [SID_W-1:0] curSid;
  logic [PRIO_W:0] actPrio;
  logic [NUM_SRC-1:0] pendVec, actVec;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSrc(cfgSrc), .cfgPrio(cfgPrio),
    .srcReq(srcReq), .ackWe(ackWe), .ackSid(ackSid), .endWe(endWe),
    .endSid(endSid), .irq(irq), .curSid(curSid), .actPrio(actPrio),
    .pendVec(pendVec), .actVec(actVec), .errFlag(errFlag));

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPrio(int sid, int p);
    cfgWe = 1; cfgSrc = SID_W'(sid); cfgPrio = PRIO_W'(p);
    cyc(1); cfgWe = 0;
  endtask

  task automatic pulse(logic [NUM_SRC-1:0] m);
    srcReq = m; cyc(1); srcReq = '0;
  endtask

  task automatic ack(int sid);
    ackWe = 1; ackSid = SID_W'(sid); cyc(1); ackWe = 0;
  endtask

  task automatic endw(int sid);
    endWe = 1; endSid = SID_W'(sid); cyc(1); endWe = 0;
  endtask

  task automatic testReset();
    check("R1 irq", irq, 0);
    check("R1 pend", pendVec, 0);
    check("R1 act", actVec, 0);
    check("R1 actPrio idle", actPrio, 8);
    check("R1 err", errFlag, 0);
  endtask

  task automatic testConfig();
    // R2: priorities used by all later scenarios
    setPrio(0, 5); setPrio(1, 3); setPrio(2, 3);
    setPrio(3, 1); setPrio(4, 6); setPrio(7, 0);
  endtask

  task automatic testTieAndAck();
    pulse(8'h07);
    check("R11 pend set", pendVec, 8'h07);
    cyc(1);
    check("R4 irq raised", irq, 1);
    check("R3 tie lowest id", curSid, 1);
    ack(1);
    check("R5 irq drop", irq, 0);
    check("R5 act set", actVec, 8'h02);
    check("R5 pend clear", pendVec, 8'h05);
    check("R5 actPrio", actPrio, 3);
    cyc(2);
    check("R4 equal prio not offered", irq, 0);
  endtask

  task automatic testNest();
    pulse(8'h08);
    cyc(1);
    check("R6 nested irq", irq, 1);
    check("R6 nested sid", curSid, 3);
    ack(3);
    check("R6 both active", actVec, 8'h0A);
    check("R6 actPrio", actPrio, 1);
  endtask

  task automatic testBadEndUnwind();
    endw(1);
    check("R9 err set", errFlag, 1);
    check("R9 act unchanged", actVec, 8'h0A);
    check("R10 err pending", pendVec, 8'h85);
    cyc(1);
    check("R10 err offered", irq, 1);
    check("R10 err sid", curSid, 7);
    ack(7);
    check("R10 err cleared", errFlag, 0);
    check("R7 actPrio err", actPrio, 0);
    endw(7);
    check("R7 restore outer", actPrio, 1);
    endw(3);
    check("R7 restore outer2", actPrio, 3);
    check("R8 act after end", actVec, 8'h02);
    cyc(1);
    check("R4 still blocked", irq, 0);
    endw(1);
    check("R8 all ended", actVec, 0);
    check("R7 idle", actPrio, 8);
    cyc(1);
    check("R2 prio order irq", irq, 1);
    check("R2 prio order sid", curSid, 2);
  endtask

  task automatic testWrongAckRepend();
    ack(0);
    check("R5 wrong ack irq", irq, 1);
    check("R5 wrong ack sid", curSid, 2);
    check("R5 wrong ack act", actVec, 0);
    ack(2);
    endw(2);
    cyc(1);
    check("R3 next sid", curSid, 0);
    ack(0);
    pulse(8'h01);
    check("R11 repend while active", pendVec, 8'h01);
    cyc(2);
    check("R11 not offered at own prio", irq, 0);
    endw(0);
    check("R8 end 0", actVec, 0);
    cyc(1);
    check("R11 offered after end", irq, 1);
    check("R11 offered sid", curSid, 0);
    ack(0);
    endw(0);
    check("R11 pend empty", pendVec, 0);
  endtask

  task automatic testIdleEnd();
    endw(5);
    check("R9 idle end err", errFlag, 1);
    check("R9 idle end act", actVec, 0);
    cyc(1);
    check("R10 idle err sid", curSid, 7);
    ack(7);
    endw(7);
    check("R8 final act", actVec, 0);
    check("R7 final idle", actPrio, 8);
    check("R10 final err", errFlag, 0);
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    testReset();
    testConfig();
    testTieAndAck();
    testNest();
    testBadEndUnwind();
    testWrongAckRepend();
    testIdleEnd();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule